// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers condition signals from a charge-port controller into three 8-bit registers. The first holds latched interrupt flags. The second mirrors the live status levels. The third holds the per-source enable masks. From these it drives one shared open-drain output pin.

Each source level is watched for edges. A latched flag is set only when its mask bit permits it, and the flags clear when software reads the interrupt register. The same pin can be handed over to a VBUS-enable signal from elsewhere in the chip. Its asserted level is selectable, so the pin can act as a pull-low or a drive-high output.

The register-file side of the block is plain. It has one read strobe for the interrupt register, one write strobe for the mask, and three data outputs. None of these paths carries a stream, so there is no valid/ready handshake and no back-pressure. A strobe always takes effect in the cycle it is high.

Top module: `isc_irq_ctrl`

## Requirements
- R1: After reset, the interrupt, status and mask registers all read 0 and the pin is released (`pin_oe` = 0).
- R2: Source levels arrive on `src_lvl`, with bit positions [7] device-detected, [6] handshake-bypassed, [5] connect-check, [3] data-session, [2] remote-wake and [1] toggle-busy. Bits [4] and [0] of `src_lvl` are ignored.
- R3: A low-to-high transition of source bit 7, 6, 5, 3 or 2 sets the interrupt flag at the same position. The flag is visible on `int_data` after the clock edge that samples the new level. A level that stays high does not set the flag again.
- R4: A rising `src_lvl[1]` sets interrupt bit 1 (toggle start). A falling `src_lvl[1]` sets interrupt bit 0 (toggle stop).
- R5: A mask bit of 0 blocks its source from setting the flag, and a mask bit of 1 allows it. The mask is loaded from `mask_wr_data` when `mask_wr_stb` is high. Mask bit 4 always reads 0.
- R6: When `int_rd_stb` is high, every latched flag clears at the next clock edge. If a flag is being set in that same cycle, the set wins.
- R7: Bits [7:2] of `stat_data` are a registered copy of the levels at the same positions, with bit 4 reading 0. Bit 1 reads 0. Bit 0 reads 1 when `src_lvl[1]` was 0 at the previous edge, which means no toggle is in progress.
- R8: In interrupt mode (`pin_fn_sel` = 0), the pin is asserted while any flag is set and `int_en` = 1. With `int_en` = 0 the pin stays released.
- R9: In VBUS mode (`pin_fn_sel` = 1), the pin is asserted exactly while `vbus_en` = 1.
- R10: When the pin is asserted, `pin_oe` = 1 and `pin_out` equals `pin_pol` (0 = pulls low, 1 = drives high). When the pin is not asserted, `pin_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | 8 | Live source levels, positioned as in R2 |
| mask_wr_stb | input | 1 | Loads the mask register |
| mask_wr_data | input | 8 | New mask value |
| int_rd_stb | input | 1 | Interrupt register read; clears the flags |
| int_en | input | 1 | Global interrupt enable for the pin |
| pin_fn_sel | input | 1 | 0 = interrupt function, 1 = VBUS enable function |
| pin_pol | input | 1 | Asserted pin level: 0 low, 1 high |
| vbus_en | input | 1 | VBUS enable request routed to the pin in VBUS mode |
| int_data | output | 8 | Latched interrupt flags |
| stat_data | output | 8 | Registered live status |
| mask_data | output | 8 | Mask register |
| pin_oe | output | 1 | Pin drive enable (open-drain) |
| pin_out | output | 1 | Level driven while `pin_oe` is 1 |

## Verification
The bench builds the block with the default 8-bit register width, which is the only width whose bit positions carry meaning. With that width, all eight flag positions can be exercised. This includes the two reserved positions and the toggle pair, whose start and stop flags come from opposite edges of a single input.

The vector table walks edges, held levels, reads that collide with new edges, and the toggle start/stop sequence, checking the pin in every row. Directed tests then cover the reset state, blocked sources, the mask's reserved bit, and both polarities. They also cover the global enable and the VBUS mode of the pin.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int REG_W = 8;

  // flag positions used by the register decoder of the neighbour
  localparam int B_DEV    = 7;
  localparam int B_BYP    = 6;
  localparam int B_CONN   = 5;
  localparam int B_RSVD   = 4;
  localparam int B_SESS   = 3;
  localparam int B_WAKE   = 2;
  localparam int B_TGL_ST = 1;
  localparam int B_TGL_SP = 0;

  // sources whose rising edge maps straight onto the same flag bit
  localparam logic [REG_W-1:0] RISE_SEL =
    (REG_W'(1) << B_DEV) | (REG_W'(1) << B_BYP) | (REG_W'(1) << B_CONN) |
    (REG_W'(1) << B_SESS) | (REG_W'(1) << B_WAKE) | (REG_W'(1) << B_TGL_ST);

  // writable mask bits (reserved bit excluded)
  localparam logic [REG_W-1:0] MASK_WR = ~(REG_W'(1) << B_RSVD);

  // live status bits copied straight from the source levels
  localparam logic [REG_W-1:0] STAT_COPY =
    (REG_W'(1) << B_DEV) | (REG_W'(1) << B_BYP) | (REG_W'(1) << B_CONN) |
    (REG_W'(1) << B_SESS) | (REG_W'(1) << B_WAKE);

  typedef enum logic {
    PIN_IRQ  = 1'b0,
    PIN_VBUS = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/isc_edge_det.sv
module isc_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/isc_flag_bank.sv
module isc_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] allow,
  input  logic         clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag_q <= 1'b0;
      else if (set_ev[i] && allow[i])   flag_q <= 1'b1;
      else if (clr)                     flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;
  end
endmodule

// File: rtl/isc_pin_mux.sv
module isc_pin_mux
  import isc_pkg::*;
(
  input  logic pend,
  input  logic int_en,
  input  logic fn_sel,
  input  logic pol,
  input  logic vbus_en,
  output logic oe,
  output logic out
);
  logic asserted;

  always_comb begin
    unique case (pin_fn_e'(fn_sel))
      PIN_IRQ:  asserted = pend & int_en;
      PIN_VBUS: asserted = vbus_en;
      default:  asserted = 1'b0;
    endcase
    oe  = asserted;
    out = pol;
  end
endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
  import isc_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_lvl,
  input  logic         mask_wr_stb,
  input  logic [W-1:0] mask_wr_data,
  input  logic         int_rd_stb,
  input  logic         int_en,
  input  logic         pin_fn_sel,
  input  logic         pin_pol,
  input  logic         vbus_en,
  output logic [W-1:0] int_data,
  output logic [W-1:0] stat_data,
  output logic [W-1:0] mask_data,
  output logic         pin_oe,
  output logic         pin_out
);
  logic [W-1:0] rise, fall, ev_vec, flags;
  logic [W-1:0] mask_q, stat_q, stat_nxt;

  isc_edge_det #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .rise(rise), .fall(fall)
  );

  // toggle stop comes from the falling edge of the busy level (bit 1)
  always_comb begin
    ev_vec = (rise & RISE_SEL) | ((fall >> (B_TGL_ST - B_TGL_SP)) & (W'(1) << B_TGL_SP));
  end

  isc_flag_bank #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_vec), .allow(mask_q),
    .clr(int_rd_stb), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '0;
    else if (mask_wr_stb) mask_q <= mask_wr_data & MASK_WR;
  end

  always_comb begin
    stat_nxt = src_lvl & STAT_COPY;
    stat_nxt[B_TGL_SP] = ~src_lvl[B_TGL_ST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  isc_pin_mux u_pin (
    .pend(|flags), .int_en(int_en), .fn_sel(pin_fn_sel), .pol(pin_pol),
    .vbus_en(vbus_en), .oe(pin_oe), .out(pin_out)
  );

  assign int_data  = flags;
  assign stat_data = stat_q;
  assign mask_data = mask_q;
endmodule

// File: rtl/isc_irq_chk.sv
module isc_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] src_lvl,
  input logic [W-1:0] ev_vec,
  input logic [W-1:0] int_data,
  input logic [W-1:0] stat_data,
  input logic [W-1:0] mask_data,
  input logic         int_rd_stb,
  input logic         int_en,
  input logic         pin_fn_sel,
  input logic         pin_pol,
  input logic         vbus_en,
  input logic         pin_oe,
  input logic         pin_out
);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_vec & mask_data) != '0) |=>
      ((int_data & $past(ev_vec & mask_data)) == $past(ev_vec & mask_data)));

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_data & ~$past(int_data) & ~$past(mask_data)) == '0));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd_stb && ((ev_vec & mask_data) == '0)) |=> (int_data == '0));

  // R7
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_data[0] == !$past(src_lvl[1])));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_data[4] && !mask_data[4] && !stat_data[4] && !stat_data[1]));

  // R8
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_fn_sel) |-> (pin_oe == (int_en && (int_data != '0))));

  // R9
  vbus_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fn_sel |-> (pin_oe == vbus_en));

  // R10
  pin_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (pin_out == pin_pol));
endmodule

bind isc_irq_ctrl isc_irq_chk #(.W(W)) u_isc_irq_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .ev_vec(ev_vec),
  .int_data(int_data), .stat_data(stat_data), .mask_data(mask_data),
  .int_rd_stb(int_rd_stb), .int_en(int_en), .pin_fn_sel(pin_fn_sel),
  .pin_pol(pin_pol), .vbus_en(vbus_en), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/isc_irq_ctrl_bench.sv
module isc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_lvl = '0;
  logic       mask_wr_stb = 1'b0;
  logic [7:0] mask_wr_data = '0;
  logic       int_rd_stb = 1'b0;
  logic       int_en = 1'b0;
  logic       pin_fn_sel = 1'b0;
  logic       pin_pol = 1'b0;
  logic       vbus_en = 1'b0;
  logic [7:0] int_data, stat_data, mask_data;
  logic       pin_oe, pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  isc_irq_ctrl u_isc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .mask_wr_stb(mask_wr_stb),
    .mask_wr_data(mask_wr_data), .int_rd_stb(int_rd_stb), .int_en(int_en),
    .pin_fn_sel(pin_fn_sel), .pin_pol(pin_pol), .vbus_en(vbus_en),
    .int_data(int_data), .stat_data(stat_data), .mask_data(mask_data),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // {src_lvl, read strobe, expected int, expected status}
  typedef struct packed {
    logic [7:0] lvl;
    logic       rd;
    logic [7:0] e_int;
    logic [7:0] e_stat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{8'h80, 1'b0, 8'h80, 8'h81},  // R3 rise bit7
    '{8'h80, 1'b0, 8'h80, 8'h81},  // R3 held level no re-set
    '{8'h80, 1'b1, 8'h00, 8'h81},  // R6 clear
    '{8'h00, 1'b0, 8'h00, 8'h01},  // R3 falling ignored
    '{8'h48, 1'b0, 8'h48, 8'h49},  // R3 two sources
    '{8'h6C, 1'b1, 8'h24, 8'h6D},  // R6 set beats clear
    '{8'h02, 1'b0, 8'h26, 8'h00},  // R4 toggle start, R7 busy
    '{8'h00, 1'b1, 8'h01, 8'h01},  // R4 toggle stop
    '{8'h00, 1'b1, 8'h00, 8'h01},  // R6 clear
    '{8'h11, 1'b0, 8'h00, 8'h01}   // R2 ignored bits
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 int", int_data, 8'h00);
    chk("R1 stat", stat_data, 8'h00);
    chk("R1 mask", mask_data, 8'h00);
    chk("R1 pin", {7'b0, pin_oe}, 8'h00);
    rst_n = 1'b1;
    int_en = 1'b1;
    @(negedge clk);
    mask_wr_stb = 1'b1; mask_wr_data = 8'hFF;
    tick();
    mask_wr_stb = 1'b0;
    chk("R5 mask bit4 reads 0", mask_data, 8'hEF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_lvl = VT[i].lvl; int_rd_stb = VT[i].rd;
      tick();
      chk("R3/R4/R6 int", int_data, VT[i].e_int);
      chk("R7 stat", stat_data, VT[i].e_stat);
      chk("R8/R10 pin", {6'b0, pin_oe, pin_out & pin_oe},
          {6'b0, (VT[i].e_int != 0), 1'b0});
    end

    // R5 blocked source
    @(negedge clk);
    src_lvl = 8'h00; int_rd_stb = 1'b1;
    mask_wr_stb = 1'b1; mask_wr_data = 8'h7F;
    tick();
    @(negedge clk);
    int_rd_stb = 1'b0; mask_wr_stb = 1'b0; src_lvl = 8'h80;
    tick();
    chk("R5 blocked bit7", int_data, 8'h00);
    @(negedge clk); src_lvl = 8'hC0;
    tick();
    chk("R5 allowed bit6", int_data, 8'h40);

    // R10 polarity high
    @(negedge clk); pin_pol = 1'b1;
    #2;
    chk("R10 high pol", {6'b0, pin_oe, pin_out}, 8'h03);
    // R8 global enable off
    @(negedge clk); int_en = 1'b0;
    #2;
    chk("R8 enable off", {7'b0, pin_oe}, 8'h00);
    // R9 VBUS mode
    @(negedge clk); pin_fn_sel = 1'b1; vbus_en = 1'b1; pin_pol = 1'b0;
    #2;
    chk("R9 vbus on", {6'b0, pin_oe, pin_out}, 8'h02);
    @(negedge clk); vbus_en = 1'b0; int_en = 1'b1;
    #2;
    chk("R9 vbus off", {7'b0, pin_oe}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule